// File: doc/BRIEF.md
# Full-Speed USB Bit-Level Packet Receiver

This block sits behind the line sampler of a full-speed USB port. The sampler gives it one already synchronized line state per bit time, marked by a bit-clock enable. The receiver hunts for the synchronization pattern that opens every packet and NRZI-decodes the line from that point. It discards the zeros that the transmitter stuffed in and packs the remaining data bits into bytes, least significant bit first.

Each finished byte is presented for one clock cycle with a valid flag. The first byte of a packet also carries a start-of-packet flag. A one-cycle end-of-packet pulse marks the line-level end of packet, and a one-cycle error pulse reports a malformed packet. After an error the packet is abandoned and the receiver returns to hunting. The block does no CRC checking, no PID validation and no transaction handling. It does no clock recovery either.

Line state encoding on `line_i` is {D+, D-}: 2'b10 is J, 2'b01 is K, 2'b00 is SE0 and 2'b11 is SE1.

Top module: `usb_bit_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid_o`, `sop_o`, `eop_o` and `err_o` are 0.
- R2: A packet starts only after eight consecutive strobed line samples that read K, J, K, J, K, J, K, K, with no SE0 or SE1 among them. The bit time after the second closing K carries the first data bit.
- R3: The first data bit is compared with the final K of the synchronization pattern. A data bit is 1 when the line level equals the level of the previous bit time, and 0 when the level changes.
- R4: Data bits are packed least significant bit first. The byte appears on `byte_o` with `valid_o` high for exactly one cycle, the cycle after the strobe that carried its eighth data bit. `sop_o` is high together with `valid_o` for the first byte of a packet only.
- R5: A decoded 0 that follows six consecutive decoded 1s is dropped. The final K of the synchronization pattern counts as the first of those 1s, so a 0 after five leading data 1s is dropped.
- R6: A stuffed 0 that is the last bit before the end of packet is also dropped and causes no error.
- R7: A seventh consecutive decoded 1 raises `err_o` for one cycle, produces no further byte and no `eop_o`, and returns the receiver to hunting.
- R8: Two consecutive strobed SE0 samples end the packet with a one-cycle `eop_o`. `err_o` is raised in the same cycle if the number of data bits received is not a multiple of eight.
- R9: Cycles with `bit_en_i` low have no effect, whatever `line_i` holds. Every output pulse follows a cycle with `bit_en_i` high.
- R10: Inside a packet, a strobed SE1, or a single SE0 followed by J or K, raises `err_o` and abandons the packet without `eop_o`.
- R11: After an end of packet or an abandoned packet, the receiver decodes the next packet correctly once a new synchronization pattern arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-time strobe: `line_i` is sampled when high |
| line_i | input | 2 | Line state {D+, D-}: 10 J, 01 K, 00 SE0, 11 SE1 |
| byte_o | output | BYTE_W | Received data byte |
| valid_o | output | 1 | One-cycle pulse: `byte_o` holds a new byte |
| sop_o | output | 1 | High with `valid_o` on the first byte of a packet |
| eop_o | output | 1 | One-cycle pulse at the line-level end of packet |
| err_o | output | 1 | One-cycle pulse on a stuffing, framing or line error |

## Verification
A wrong run count in the destuffer shows at the ports within a single byte. If the count starts late, the stuffed zero that follows five leading data ones is kept as data: the byte shifts and one `valid_o` appears too many or too few before `eop_o`. A wrong bit counter or a wrong first-byte flag shows at the next `valid_o`, as a misplaced `sop_o` or a byte built from the wrong bits. A receiver that does not fall back to hunting after an error shows at the following packet, which then comes out missing or garbled.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    // Line state codes, {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    // Synchronization pattern length and shape, oldest sample in the MSB,
    // a K sample is 1 and a J sample is 0: K J K J K J K K
    localparam int SYNC_LEN = 8;
    localparam logic [SYNC_LEN-1:0] SYNC_PAT = 8'b1010_1011;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } rx_state_e;

endpackage

// File: rtl/usb_rx_sync_hunt.sv
module usb_rx_sync_hunt
    import usb_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable_i,
    input  logic  strobe_i,
    input  line_e line_i,
    output logic  hit_o
);
    localparam int HW = SYNC_LEN - 1;
    localparam int FW = $clog2(SYNC_LEN);
    localparam logic [FW-1:0] FULL = FW'(HW);

    typedef struct packed {
        logic [HW-1:0] hist;
        logic [FW-1:0] fill;
    } hunt_t;

    hunt_t hunt_d, hunt_q;
    logic  is_k, is_lvl;

    always_comb begin
        is_k   = (line_i == LN_K);
        is_lvl = (line_i == LN_K) || (line_i == LN_J);
        hit_o  = enable_i && strobe_i && is_lvl && (hunt_q.fill == FULL)
                 && ({hunt_q.hist, is_k} == SYNC_PAT);

        hunt_d = hunt_q;
        if (!enable_i || hit_o) begin
            hunt_d = '0;
        end else if (strobe_i) begin
            if (!is_lvl) begin
                hunt_d = '0;
            end else begin
                hunt_d.hist = {hunt_q.hist[HW-2:0], is_k};
                if (hunt_q.fill != FULL) begin
                    hunt_d.fill = hunt_q.fill + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hunt_q <= '0;
        end else begin
            hunt_q <= hunt_d;
        end
    end

endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
    parameter int MAX_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic step_i,
    input  logic bit_i,
    output logic drop_o,
    output logic viol_o
);
    localparam int CW = $clog2(MAX_RUN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_RUN);

    typedef struct packed {
        logic [CW-1:0] run;
    } run_t;

    run_t run_d, run_q;
    logic at_limit;

    always_comb begin
        at_limit = (run_q.run == LIMIT);
        drop_o   = at_limit && !bit_i;
        viol_o   = at_limit && bit_i;

        run_d = run_q;
        if (restart_i) begin
            // The closing K of the sync pattern is the first 1 of a run
            run_d.run = CW'(1);
        end else if (step_i) begin
            if (at_limit || !bit_i) begin
                run_d.run = '0;
            end else begin
                run_d.run = run_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/usb_rx_byte_pack.sv
module usb_rx_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic              partial_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        // Shift right so the first bit received ends in bit 0
        byte_o    = {bit_i, pk_q.sh[BYTE_W-1:1]};
        done_o    = (pk_q.cnt == LAST);
        partial_o = (pk_q.cnt != '0);

        pk_d = pk_q;
        if (clear_i) begin
            pk_d = '0;
        end else if (push_i) begin
            pk_d.sh = byte_o;
            if (done_o) begin
                pk_d.cnt = '0;
            end else begin
                pk_d.cnt = pk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

endmodule

// File: rtl/usb_bit_rx.sv
module usb_bit_rx
    import usb_rx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int MAX_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic [1:0]        line_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              sop_o,
    output logic              eop_o,
    output logic              err_o
);
    typedef struct packed {
        rx_state_e         state;
        logic              prev_k;
        logic              se0_seen;
        logic              first;
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              sop;
        logic              eop;
        logic              err;
    } rx_t;

    rx_t rx_d, rx_q;

    line_e             line_s;
    logic              hunting;
    logic              sync_hit;
    logic              dbit;
    logic              step;
    logic              push;
    logic              drop;
    logic              viol;
    logic              done;
    logic              partial;
    logic [BYTE_W-1:0] packed_byte;

    assign line_s  = line_e'(line_i);
    assign hunting = (rx_q.state == ST_HUNT);

    usb_rx_sync_hunt i_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (hunting),
        .strobe_i (bit_en_i),
        .line_i   (line_s),
        .hit_o    (sync_hit)
    );

    usb_rx_destuff #(
        .MAX_RUN (MAX_RUN)
    ) i_destuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (hunting),
        .step_i    (step),
        .bit_i     (dbit),
        .drop_o    (drop),
        .viol_o    (viol)
    );

    usb_rx_byte_pack #(
        .BYTE_W (BYTE_W)
    ) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (hunting),
        .push_i    (push),
        .bit_i     (dbit),
        .done_o    (done),
        .partial_o (partial),
        .byte_o    (packed_byte)
    );

    always_comb begin
        // NRZI: same level as the last bit time decodes as 1
        dbit = ((line_s == LN_K) == rx_q.prev_k);
        step = 1'b0;
        push = 1'b0;

        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        rx_d.sop   = 1'b0;
        rx_d.eop   = 1'b0;
        rx_d.err   = 1'b0;

        unique case (rx_q.state)
            ST_HUNT: begin
                if (sync_hit) begin
                    rx_d.state    = ST_DATA;
                    rx_d.prev_k   = 1'b1;
                    rx_d.se0_seen = 1'b0;
                    rx_d.first    = 1'b1;
                end
            end
            ST_DATA: begin
                if (bit_en_i) begin
                    if (line_s == LN_SE1) begin
                        rx_d.err   = 1'b1;
                        rx_d.state = ST_HUNT;
                    end else if (line_s == LN_SE0) begin
                        if (rx_q.se0_seen) begin
                            rx_d.eop   = 1'b1;
                            rx_d.err   = partial;
                            rx_d.state = ST_HUNT;
                        end else begin
                            rx_d.se0_seen = 1'b1;
                        end
                    end else if (rx_q.se0_seen) begin
                        rx_d.err   = 1'b1;
                        rx_d.state = ST_HUNT;
                    end else begin
                        step        = 1'b1;
                        rx_d.prev_k = (line_s == LN_K);
                        if (viol) begin
                            rx_d.err   = 1'b1;
                            rx_d.state = ST_HUNT;
                        end else if (!drop) begin
                            push = 1'b1;
                            if (done) begin
                                rx_d.data  = packed_byte;
                                rx_d.valid = 1'b1;
                                rx_d.sop   = rx_q.first;
                                rx_d.first = 1'b0;
                            end
                        end
                    end
                end
            end
            default: rx_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_o  = rx_q.data;
    assign valid_o = rx_q.valid;
    assign sop_o   = rx_q.sop;
    assign eop_o   = rx_q.eop;
    assign err_o   = rx_q.err;

endmodule

// File: rtl/usb_bit_rx_chk.sv
module usb_bit_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en_i,
    input logic [1:0] line_i,
    input logic       valid_o,
    input logic       sop_o,
    input logic       eop_o,
    input logic       err_o
);
    // R4: a byte is flagged for a single cycle
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R4: start of packet only rides on a byte
    assert_sop_with_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |-> valid_o);

    // R9: every output pulse follows a strobed bit time
    assert_pulse_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || eop_o || err_o) |-> $past(bit_en_i));

    // R8: end of packet is reported on an SE0 sample, never with a byte
    assert_eop_on_se0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> ($past(line_i) == 2'b00) && !valid_o);

    // R7: an error never delivers a byte
    assert_err_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

endmodule

bind usb_bit_rx usb_bit_rx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en_i (bit_en_i),
    .line_i   (line_i),
    .valid_o  (valid_o),
    .sop_o    (sop_o),
    .eop_o    (eop_o),
    .err_o    (err_o)
);

// File: tb/test_usb_bit_rx.sv
module test_usb_bit_rx;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] LJ   = 2'b10;
    localparam logic [1:0] LK   = 2'b01;
    localparam logic [1:0] LSE0 = 2'b00;
    localparam logic [1:0] LSE1 = 2'b11;

    // Vector table: [39:32] byte count, bytes packed from bit 0 upward
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        40'h02_0000_5AC3,   // mixed levels
        40'h01_0000_001F,   // five leading ones: stuff counted from sync (R5)
        40'h02_0000_FFFF,   // long runs of ones
        40'h03_00FC_8000,   // six trailing ones: stuff before EOP (R6)
        40'h04_3CA5_7E01,   // assorted
        40'h01_0000_0000    // all transitions
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] line = LJ;
    logic [7:0] byte_out;
    logic       valid, sop, eop, err;

    int total = 0;
    int fails = 0;

    logic [7:0] rx_byte [256];
    logic       rx_sop  [256];
    int rx_n = 0;
    int eop_n = 0;
    int err_n = 0;
    int eoperr_n = 0;

    logic lvl_k = 1'b0;
    int   ones = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_bit_rx i_usb_bit_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en_i (bit_en),
        .line_i   (line),
        .byte_o   (byte_out),
        .valid_o  (valid),
        .sop_o    (sop),
        .eop_o    (eop),
        .err_o    (err)
    );

    // Monitor samples mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid && rx_n < 256) begin
                rx_byte[rx_n] = byte_out;
                rx_sop[rx_n]  = sop;
                rx_n++;
            end
            if (eop) eop_n++;
            if (err) err_n++;
            if (eop && err) eoperr_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed bit time, then a non-strobed cycle holding junk (R9)
    task automatic put(input logic [1:0] l);
        @(negedge clk);
        line   = l;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        line   = LSE1;
    endtask

    task automatic send_sync();
        put(LK); put(LJ); put(LK); put(LJ);
        put(LK); put(LJ); put(LK); put(LK);
        lvl_k = 1'b1;
        ones  = 1;
    endtask

    task automatic send_bit(input logic b);
        if (b) begin
            put(lvl_k ? LK : LJ);
            ones++;
            if (ones == 6) begin
                lvl_k = !lvl_k;
                put(lvl_k ? LK : LJ);
                ones = 0;
            end
        end else begin
            lvl_k = !lvl_k;
            put(lvl_k ? LK : LJ);
            ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_eop();
        put(LSE0); put(LSE0); put(LJ); put(LJ);
    endtask

    initial begin
        int base, eb, er;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(valid), 0);
        chk("R1 eop/err in reset", 32'({eop, err, sop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", 32'({valid, sop, eop, err}), 0);
        put(LJ); put(LJ);

        // Table-driven packets (R3, R4, R5, R6, R8, R11)
        for (int v = 0; v < NV; v++) begin
            int n;
            n = int'(VEC[v][39:32]);
            base = rx_n; eb = eop_n; er = err_n;
            send_sync();
            for (int i = 0; i < n; i++) send_byte(VEC[v][8*i +: 8]);
            send_eop();
            chk("R4 byte count", 32'(rx_n - base), 32'(n));
            for (int i = 0; i < n; i++) begin
                chk("R3 R5 R6 byte value", 32'(rx_byte[base+i]), 32'(VEC[v][8*i +: 8]));
                chk("R4 sop flag", 32'(rx_sop[base+i]), 32'(i == 0));
            end
            chk("R8 eop count", 32'(eop_n - eb), 1);
            chk("R5 R6 no error", 32'(err_n - er), 0);
        end

        // R7: seven ones in a row
        base = rx_n; eb = eop_n; er = err_n;
        send_sync();
        repeat (8) put(LK);
        put(LJ); put(LJ);
        chk("R7 error raised", 32'(err_n - er), 1);
        chk("R7 no eop", 32'(eop_n - eb), 0);
        chk("R7 no byte", 32'(rx_n - base), 0);

        // R11: clean packet after the abandoned one
        base = rx_n; er = err_n;
        send_sync(); send_byte(8'hA5); send_eop();
        chk("R11 byte count", 32'(rx_n - base), 1);
        chk("R11 byte value", 32'(rx_byte[base]), 32'hA5);
        chk("R11 no error", 32'(err_n - er), 0);

        // R8: partial byte at end of packet
        base = rx_n; eb = eop_n; er = eoperr_n;
        send_sync();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_eop();
        chk("R8 partial eop", 32'(eop_n - eb), 1);
        chk("R8 partial error with eop", 32'(eoperr_n - er), 1);
        chk("R8 partial no byte", 32'(rx_n - base), 0);

        // R10: lone SE0 followed by J
        base = rx_n; eb = eop_n; er = err_n;
        send_sync(); send_byte(8'h33);
        put(LSE0); put(LJ); put(LJ); put(LJ);
        chk("R10 lone SE0 error", 32'(err_n - er), 1);
        chk("R10 lone SE0 no eop", 32'(eop_n - eb), 0);
        chk("R10 byte before SE0", 32'(rx_byte[base]), 32'h33);

        // R10: SE1 inside packet
        eb = eop_n; er = err_n;
        send_sync(); send_bit(1'b0);
        put(LSE1); put(LJ); put(LJ);
        chk("R10 SE1 error", 32'(err_n - er), 1);
        chk("R10 SE1 no eop", 32'(eop_n - eb), 0);

        // R2: near misses must not start a packet
        base = rx_n; eb = eop_n; er = err_n;
        put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ);
        put(LJ); put(LJ);
        put(LK); put(LJ); put(LK); put(LJ); put(LSE0);
        put(LK); put(LJ); put(LK); put(LK);
        repeat (10) put(LJ);
        chk("R2 no bytes", 32'(rx_n - base), 0);
        chk("R2 no error", 32'(err_n - er), 0);
        chk("R2 no eop", 32'(eop_n - eb), 0);

        // R9: unstrobed junk mid-packet has no effect
        base = rx_n; er = err_n;
        send_sync(); send_byte(8'h5A);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            bit_en = 1'b0;
            line   = 2'(c);
        end
        send_byte(8'h96); send_eop();
        chk("R9 byte count", 32'(rx_n - base), 2);
        chk("R9 byte0", 32'(rx_byte[base]), 32'h5A);
        chk("R9 byte1", 32'(rx_byte[base+1]), 32'h96);
        chk("R9 no error", 32'(err_n - er), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule